// File: doc/BRIEF.md
# Sixteen-Bit Window onto Thirty-Six-Bit Memory

This block lets a requester with a 16-bit data path read and write the 16-bit
slices of a memory whose words are 36 bits wide. The requester names one of
several windows. Each window has a 36-bit descriptor, applied on a flat input
bus. Bit numbering follows the wide word's convention: bit 0 is the most
significant bit, so descriptor bit k is vector index 35-k.

A descriptor whose mode bit (index 32) is 0 is immediate. Its low 16 bits,
[15:0], are the data. A read returns them without touching memory, and a write
is acknowledged with no effect. A descriptor whose mode bit is 1 is indirect.
Index 35 is a read-only flag, [34:33] is a position code, and the low `ADDR_W`
bits hold the memory address.

For an indirect window, a read fetches the word and returns the selected slice.
A write fetches the word, replaces only the selected slice, stores the word back
and then acknowledges. A write to a read-only window is refused without any
memory traffic. A memory error ends the transaction with a nonexistent-memory
flag.

Top module: `slice_window`

## Requirements
- R1: For an indirect read, `req_rdata` is the slice picked by the position code: code 0 gives word[35:20], code 1 gives [19:4], code 2 gives [15:0] and code 3 gives [33:18]. `req_ack` rises 3 cycles after the accepting edge when memory answers one cycle after each request.
- R2: An immediate descriptor (index 32 = 0) read returns descriptor[15:0] with `req_ack` one cycle after acceptance, and issues no memory request.
- R3: An indirect write to a writable window (index 35 = 0) reads the word, then writes it back with only the selected slice replaced, and acknowledges after the write completes (5 cycles under the same memory timing).
- R4: A write to a read-only indirect window (index 35 = 1) issues no memory request and leaves memory unchanged. It is acknowledged one cycle after acceptance, with `req_viol` high for exactly that acknowledge cycle.
- R5: A read-only window still serves reads exactly as in R1.
- R6: If `mem_err` accompanies `mem_ack`, the transaction is acknowledged with `req_nxm` high. If this happens on the read phase of a write, no write is issued.
- R7: While reset is held and after its release with no request, `req_ack`, `req_viol`, `req_nxm` and `mem_req` are low.
- R8: Once raised, `mem_req`, together with `mem_addr` and `mem_we`, holds steady until `mem_ack`.
- R9: A write through an immediate descriptor is acknowledged in one cycle, with no memory request and no violation.
- R10: Each accepted request produces exactly one single-cycle `req_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| win_desc | input | NWIN*36 | Descriptors, window i at [i*36 +: 36] |
| req_valid | input | 1 | Request present; held until `req_ack` |
| req_write | input | 1 | 1 = write, 0 = read |
| req_win | input | $clog2(NWIN) | Window index |
| req_wdata | input | 16 | Write data |
| req_ack | output | 1 | One-cycle completion pulse |
| req_rdata | output | 16 | Read data, valid with `req_ack` |
| req_nxm | output | 1 | Memory error, valid with `req_ack` |
| req_viol | output | 1 | Write refused on read-only window, valid with `req_ack` |
| mem_req | output | 1 | Memory request, held until `mem_ack` |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | ADDR_W | Memory word address |
| mem_wdata | output | 36 | Merged word to store |
| mem_ack | input | 1 | Memory completion, one cycle |
| mem_rdata | input | 36 | Memory read word, valid with `mem_ack` |
| mem_err | input | 1 | Memory error, valid with `mem_ack` |

## Verification
A latched position code that is wrong shows at once as the wrong slice on the
next read. On a write, it shows as a corrupted neighbour field, visible in the
following read of the same word. A wrong sequencer state shows within one
transaction, as an acknowledge that is early, late, doubled or missing, or as
memory traffic on a refused or immediate access. The sweep compares every
acknowledge cycle count, and every word in the memory model, against values
computed from the bit-numbering rule.

// File: rtl/sw_pkg.sv
package sw_pkg;
  localparam int WORD_W    = 36;
  localparam int SLICE_W   = 16;
  localparam int POS_W     = 2;
  localparam int POS_COUNT = 4;
  localparam int IDX_RO    = 35;
  localparam int IDX_POSH  = 34;
  localparam int IDX_POSL  = 33;
  localparam int IDX_MODE  = 32;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RD   = 2'd1,
    ST_WR   = 2'd2,
    ST_DONE = 2'd3
  } sw_state_e;

  // Vector index of the least significant bit of slice p.
  // MSB-first numbering: slice starting at bit s occupies [35-s : 20-s].
  function automatic int slice_lo(input int p);
    case (p)
      0:       return 20;
      1:       return 4;
      2:       return 0;
      default: return 18;
    endcase
  endfunction
endpackage

// File: rtl/sw_desc_decode.sv
module sw_desc_decode #(
  parameter int NWIN   = 4,
  parameter int ADDR_W = 8,
  localparam int WIN_W = $clog2(NWIN)
) (
  input  logic [NWIN*sw_pkg::WORD_W-1:0] desc_flat_i,
  input  logic [WIN_W-1:0]               win_i,
  output logic                           indirect_o,
  output logic                           ro_o,
  output logic [sw_pkg::POS_W-1:0]       pos_o,
  output logic [ADDR_W-1:0]              addr_o,
  output logic [sw_pkg::SLICE_W-1:0]     imm_o
);
  import sw_pkg::*;

  logic [WORD_W-1:0] desc_sel;
  logic              unused_bits;

  always_comb begin
    desc_sel = '0;
    for (int i = 0; i < NWIN; i++) begin
      if (win_i == WIN_W'(i)) desc_sel = desc_flat_i[i*WORD_W +: WORD_W];
    end
  end

  assign indirect_o  = desc_sel[IDX_MODE];
  assign ro_o        = desc_sel[IDX_RO];
  assign pos_o       = desc_sel[IDX_POSH:IDX_POSL];
  assign addr_o      = desc_sel[ADDR_W-1:0];
  assign imm_o       = desc_sel[SLICE_W-1:0];
  assign unused_bits = ^desc_sel;
endmodule

// File: rtl/sw_slice_unit.sv
module sw_slice_unit (
  input  logic [sw_pkg::WORD_W-1:0]  word_i,
  input  logic [sw_pkg::POS_W-1:0]   pos_i,
  input  logic [sw_pkg::SLICE_W-1:0] wdata_i,
  output logic [sw_pkg::SLICE_W-1:0] slice_o,
  output logic [sw_pkg::WORD_W-1:0]  merged_o
);
  import sw_pkg::*;

  logic [POS_COUNT-1:0][SLICE_W-1:0] cand;
  logic [POS_COUNT-1:0][WORD_W-1:0]  mcand;

  for (genvar p = 0; p < POS_COUNT; p++) begin : g_pos
    localparam int LO = slice_lo(p);
    localparam logic [WORD_W-1:0] MASK = {{(WORD_W-SLICE_W){1'b0}}, {SLICE_W{1'b1}}} << LO;
    assign cand[p]  = word_i[LO +: SLICE_W];
    assign mcand[p] = (word_i & ~MASK) |
                      ({{(WORD_W-SLICE_W){1'b0}}, wdata_i} << LO);
  end

  assign slice_o  = cand[pos_i];
  assign merged_o = mcand[pos_i];
endmodule

// File: rtl/sw_ctrl.sv
module sw_ctrl #(
  parameter int ADDR_W = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        req_valid_i,
  input  logic                        req_write_i,
  input  logic [sw_pkg::SLICE_W-1:0]  req_wdata_i,
  input  logic                        d_indirect_i,
  input  logic                        d_ro_i,
  input  logic [sw_pkg::POS_W-1:0]    d_pos_i,
  input  logic [ADDR_W-1:0]           d_addr_i,
  input  logic [sw_pkg::SLICE_W-1:0]  d_imm_i,
  input  logic [sw_pkg::SLICE_W-1:0]  slice_i,
  input  logic [sw_pkg::WORD_W-1:0]   merged_i,
  output logic [sw_pkg::POS_W-1:0]    pos_o,
  output logic [sw_pkg::SLICE_W-1:0]  wdata_o,
  output logic                        ack_o,
  output logic [sw_pkg::SLICE_W-1:0]  rdata_o,
  output logic                        nxm_o,
  output logic                        viol_o,
  output logic                        mem_req_o,
  output logic                        mem_we_o,
  output logic [ADDR_W-1:0]           mem_addr_o,
  output logic [sw_pkg::WORD_W-1:0]   mem_wdata_o,
  input  logic                        mem_ack_i,
  input  logic                        mem_err_i
);
  import sw_pkg::*;

  sw_state_e           state_q, state_d;
  logic [ADDR_W-1:0]   addr_q, addr_d;
  logic [POS_W-1:0]    pos_q, pos_d;
  logic                ro_q, ro_d;
  logic                write_q, write_d;
  logic [SLICE_W-1:0]  wdata_q, wdata_d;
  logic [SLICE_W-1:0]  rdata_q, rdata_d;
  logic                nxm_q, nxm_d;
  logic                viol_q, viol_d;
  logic [WORD_W-1:0]   wword_q, wword_d;
  logic                accept;

  assign accept = (state_q == ST_IDLE) && req_valid_i;

  always_comb begin
    state_d = state_q;
    addr_d  = addr_q;
    pos_d   = pos_q;
    ro_d    = ro_q;
    write_d = write_q;
    wdata_d = wdata_q;
    rdata_d = rdata_q;
    nxm_d   = nxm_q;
    viol_d  = viol_q;
    wword_d = wword_q;
    case (state_q)
      ST_IDLE: begin
        if (accept) begin
          addr_d  = d_addr_i;
          pos_d   = d_pos_i;
          ro_d    = d_ro_i;
          write_d = req_write_i;
          wdata_d = req_wdata_i;
          rdata_d = '0;
          nxm_d   = 1'b0;
          viol_d  = 1'b0;
          if (!d_indirect_i) begin
            if (!req_write_i) rdata_d = d_imm_i;
            ro_d    = 1'b0;
            state_d = ST_DONE;
          end else if (req_write_i && d_ro_i) begin
            viol_d  = 1'b1;
            state_d = ST_DONE;
          end else begin
            state_d = ST_RD;
          end
        end
      end
      ST_RD: begin
        if (mem_ack_i) begin
          if (mem_err_i) begin
            nxm_d   = 1'b1;
            state_d = ST_DONE;
          end else if (write_q) begin
            wword_d = merged_i;
            state_d = ST_WR;
          end else begin
            rdata_d = slice_i;
            state_d = ST_DONE;
          end
        end
      end
      ST_WR: begin
        if (mem_ack_i) begin
          nxm_d   = mem_err_i;
          state_d = ST_DONE;
        end
      end
      default: begin
        viol_d  = 1'b0;
        state_d = ST_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      pos_q   <= '0;
      ro_q    <= 1'b0;
      write_q <= 1'b0;
      wdata_q <= '0;
      rdata_q <= '0;
      nxm_q   <= 1'b0;
      viol_q  <= 1'b0;
      wword_q <= '0;
    end else begin
      state_q <= state_d;
      addr_q  <= addr_d;
      pos_q   <= pos_d;
      ro_q    <= ro_d;
      write_q <= write_d;
      wdata_q <= wdata_d;
      rdata_q <= rdata_d;
      nxm_q   <= nxm_d;
      viol_q  <= viol_d;
      wword_q <= wword_d;
    end
  end

  assign pos_o       = pos_q;
  assign wdata_o     = wdata_q;
  assign ack_o       = (state_q == ST_DONE);
  assign rdata_o     = rdata_q;
  assign nxm_o       = ack_o && nxm_q;
  assign viol_o      = viol_q;
  assign mem_req_o   = (state_q == ST_RD) || (state_q == ST_WR);
  assign mem_we_o    = (state_q == ST_WR);
  assign mem_addr_o  = addr_q;
  assign mem_wdata_o = wword_q;

  assert_ro_no_store_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we_o |-> !ro_q);

  assert_viol_on_ack_R4: assert property (@(posedge clk) disable iff (!rst_n)
    viol_o |-> ack_o);

  assert_req_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o)));

  assert_store_after_fetch_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_o) |-> ($past(mem_ack_i) && !$past(mem_err_i)));

  assert_single_ack_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ack_o |=> !ack_o);
endmodule

// File: rtl/slice_window.sv
module slice_window #(
  parameter int NWIN   = 4,
  parameter int ADDR_W = 8,
  localparam int WIN_W = $clog2(NWIN),
  localparam int DW    = NWIN * sw_pkg::WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DW-1:0]     win_desc,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [WIN_W-1:0]  req_win,
  input  logic [15:0]       req_wdata,
  output logic              req_ack,
  output logic [15:0]       req_rdata,
  output logic              req_nxm,
  output logic              req_viol,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [35:0]       mem_wdata,
  input  logic              mem_ack,
  input  logic [35:0]       mem_rdata,
  input  logic              mem_err
);
  import sw_pkg::*;

  logic               rst_meta, rst_sync;
  logic               d_indirect, d_ro;
  logic [POS_W-1:0]   d_pos, pos_q;
  logic [ADDR_W-1:0]  d_addr;
  logic [SLICE_W-1:0] d_imm, slice, wdata_q;
  logic [WORD_W-1:0]  merged;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  sw_desc_decode #(.NWIN(NWIN), .ADDR_W(ADDR_W)) u_dec (
    .desc_flat_i(win_desc), .win_i(req_win),
    .indirect_o(d_indirect), .ro_o(d_ro), .pos_o(d_pos),
    .addr_o(d_addr), .imm_o(d_imm)
  );

  sw_slice_unit u_slice (
    .word_i(mem_rdata), .pos_i(pos_q), .wdata_i(wdata_q),
    .slice_o(slice), .merged_o(merged)
  );

  sw_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rst_n(rst_sync),
    .req_valid_i(req_valid), .req_write_i(req_write), .req_wdata_i(req_wdata),
    .d_indirect_i(d_indirect), .d_ro_i(d_ro), .d_pos_i(d_pos),
    .d_addr_i(d_addr), .d_imm_i(d_imm),
    .slice_i(slice), .merged_i(merged),
    .pos_o(pos_q), .wdata_o(wdata_q),
    .ack_o(req_ack), .rdata_o(req_rdata), .nxm_o(req_nxm), .viol_o(req_viol),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_ack_i(mem_ack), .mem_err_i(mem_err)
  );
endmodule

// File: tb/slice_window_tb.sv
module slice_window_tb;
  localparam int NWIN = 4;
  localparam int AW   = 8;

  logic              clk = 1'b0;
  logic              rst_n;
  logic [NWIN*36-1:0] win_desc;
  logic              req_valid, req_write;
  logic [1:0]        req_win;
  logic [15:0]       req_wdata;
  logic              req_ack, req_nxm, req_viol;
  logic [15:0]       req_rdata;
  logic              mem_req, mem_we;
  logic [AW-1:0]     mem_addr;
  logic [35:0]       mem_wdata;
  logic              m_ack, m_err;
  logic [35:0]       m_rdata;

  logic [35:0] mem [256];
  logic [35:0] shadow [256];
  int total = 0, bad = 0;
  int req_cnt = 0, wr_cnt = 0, ack_cnt = 0, hold_bad = 0;
  logic [AW-1:0] prev_addr;
  logic prev_we, prev_pend;

  always #10 clk = ~clk;

  slice_window #(.NWIN(NWIN), .ADDR_W(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .win_desc(win_desc),
    .req_valid(req_valid), .req_write(req_write), .req_win(req_win),
    .req_wdata(req_wdata), .req_ack(req_ack), .req_rdata(req_rdata),
    .req_nxm(req_nxm), .req_viol(req_viol),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(m_ack), .mem_rdata(m_rdata), .mem_err(m_err)
  );

  function automatic logic [35:0] init_word(input int a);
    return (36'(a) * 36'h0_1357_9BDF) ^ 36'hA_5C3E_96F1;
  endfunction

  function automatic int lo_of(input int p);
    int start;
    case (p) 0: start = 0; 1: start = 16; 2: start = 20; default: start = 2; endcase
    return 20 - start;
  endfunction

  // Memory model: answers one cycle after a request, error on addresses F0..FF.
  always @(posedge clk) begin
    if (!rst_n) begin
      m_ack <= 1'b0; m_err <= 1'b0; m_rdata <= '0;
      for (int i = 0; i < 256; i++) mem[i] <= init_word(i);
    end else if (mem_req && !m_ack) begin
      m_ack   <= 1'b1;
      m_err   <= (mem_addr[7:4] == 4'hF);
      m_rdata <= mem[mem_addr];
      req_cnt <= req_cnt + 1;
      if (mem_we && mem_addr[7:4] != 4'hF) begin
        mem[mem_addr] <= mem_wdata;
        wr_cnt <= wr_cnt + 1;
      end
    end else begin
      m_ack <= 1'b0;
    end
  end

  // Monitor: ack pulses and request hold (R8).
  always @(posedge clk) begin
    if (!rst_n) begin
      prev_pend <= 1'b0; prev_addr <= '0; prev_we <= 1'b0;
    end else begin
      if (req_ack) ack_cnt <= ack_cnt + 1;
      if (prev_pend && (!mem_req || mem_addr != prev_addr || mem_we != prev_we))
        hold_bad <= hold_bad + 1;
      prev_pend <= mem_req && !m_ack;
      prev_addr <= mem_addr;
      prev_we   <= mem_we;
    end
  end

  task automatic check(input bit ok, input string rq, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic xact(input int w, input bit wr, input logic [15:0] d,
                      output logic [15:0] rd, output bit nx, output bit vi, output int cyc);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_win = 2'(w); req_wdata = d; cyc = 0;
    do begin @(negedge clk); cyc++; end while (!req_ack && cyc < 50);
    rd = req_rdata; nx = req_nxm; vi = req_viol;
    req_valid = 1'b0;
  endtask

  task automatic set_desc(input int w, input logic [35:0] d);
    win_desc[w*36 +: 36] = d;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0] rd; bit nx, vi; int cyc, r0, w0, n_x;
    logic [35:0] exp_w;
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_win = '0; req_wdata = '0;
    win_desc = '0;
    for (int i = 0; i < 256; i++) shadow[i] = init_word(i);
    repeat (3) @(negedge clk);
    check(!req_ack && !req_viol && !req_nxm && !mem_req, "R7 in reset",
          {req_ack, req_viol, req_nxm, mem_req}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(!req_ack && !req_viol && !req_nxm && !mem_req, "R7 after release",
          {req_ack, req_viol, req_nxm, mem_req}, 0);
    n_x = 0;

    // Sweep windows x positions x read-only flag x patterns.
    for (int w = 0; w < NWIN; w++)
      for (int p = 0; p < 4; p++)
        for (int ro = 0; ro < 2; ro++) begin
          int a = w * 16 + p * 4 + ro + 1;
          logic [15:0] pat = 16'(a * 16'h3A5 ^ 16'hC3F0);
          set_desc(w, {1'(ro), 2'(p), 1'b1, 24'h0, 8'(a)});
          xact(w, 1'b0, 16'h0, rd, nx, vi, cyc); n_x++;
          check(rd == shadow[a][lo_of(p) +: 16], ro ? "R5 ro read" : "R1 slice read",
                rd, shadow[a][lo_of(p) +: 16]);
          check(cyc == 3 && !nx && !vi, "R1 read timing", cyc, 3);
          r0 = req_cnt; w0 = wr_cnt;
          xact(w, 1'b1, pat, rd, nx, vi, cyc); n_x++;
          if (ro) begin
            check(vi && cyc == 1, "R4 refused write", {vi, 8'(cyc)}, {1'b1, 8'd1});
            check(req_cnt == r0 && mem[a] == shadow[a], "R4 memory untouched",
                  mem[a], shadow[a]);
          end else begin
            exp_w = (shadow[a] & ~(36'hFFFF << lo_of(p))) | (36'(pat) << lo_of(p));
            shadow[a] = exp_w;
            check(cyc == 5 && !vi && !nx, "R3 write timing", cyc, 5);
            check(mem[a] == exp_w && wr_cnt == w0 + 1, "R3 merged word", mem[a], exp_w);
            xact(w, 1'b0, 16'h0, rd, nx, vi, cyc); n_x++;
            check(rd == pat, "R3 readback", rd, pat);
          end
        end

    // Immediate descriptors: upper bits set to show they are ignored.
    for (int w = 0; w < NWIN; w++) begin
      logic [15:0] iv = 16'(16'h1F2E * (w + 1));
      set_desc(w, {1'b1, 2'b11, 1'b0, 16'hBEEF, iv});
      r0 = req_cnt;
      xact(w, 1'b0, 16'h0, rd, nx, vi, cyc); n_x++;
      check(rd == iv && cyc == 1 && req_cnt == r0, "R2 immediate read", rd, iv);
      xact(w, 1'b1, 16'h5555, rd, nx, vi, cyc); n_x++;
      check(cyc == 1 && !vi && !nx && req_cnt == r0, "R9 immediate write",
            {vi, nx, 8'(cyc)}, 1);
    end

    // Memory error on read and on the fetch of a write.
    set_desc(2, {1'b0, 2'd1, 1'b1, 24'h0, 8'hF3});
    xact(2, 1'b0, 16'h0, rd, nx, vi, cyc); n_x++;
    check(nx && cyc == 3, "R6 error read", {nx, 8'(cyc)}, {1'b1, 8'd3});
    w0 = wr_cnt; r0 = req_cnt;
    xact(2, 1'b1, 16'h1234, rd, nx, vi, cyc); n_x++;
    check(nx && cyc == 3 && req_cnt == r0 + 1 && wr_cnt == w0, "R6 error write",
          req_cnt - r0, 1);
    xact(2, 1'b0, 16'h0, rd, nx, vi, cyc); n_x++;
    check(nx, "R6 flag repeats", nx, 1);

    repeat (3) @(negedge clk);
    check(ack_cnt == n_x, "R10 one ack per request", ack_cnt, n_x);
    check(hold_bad == 0, "R8 request held until ack", hold_bad, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule